// File: doc/BRIEF.md
# Quarter-Bit Event Scheduler

This block schedules output events against a quarter-bit timebase. A divider turns the 13 MHz system clock into one tick every twelve clocks. A frame counter counts those ticks and wraps at a programmable frame length. Before or during a run, a host fills a sixteen-entry event table. Each entry holds a tick time, a masked value for the control lines, and an optional seven-bit word for an attached serial-port engine.

When the tick counter reaches an entry's time, the control lines take the masked value. The serial engine also receives a one-cycle request together with the word. Both happen in the same cycle that the counter shows that time. The table stays in place, so a programmed sequence repeats on every frame until the host rewrites it.

Only control lines 0 to 4 and line 9 exist. Lines 5 to 8 are held low. The block does not forward the 13 MHz clock, and it does not shift serial data itself.

Top module: `qbit_event_sched`

## Requirements
- R1: Reset (rst_n low, released through a two-stage synchronizer) clears act_out, ser_req, tick_count, qtick_stb and frame_start to 0. It also marks every table entry invalid, so a run with no writes changes no output.
- R2: While run_en is low, tick_count is 0 and no tick strobe or event occurs. Dropping run_en returns tick_count to 0 one cycle later and leaves act_out unchanged. The cycle after run_en is first sampled high, tick 0 begins: qtick_stb and frame_start are both 1 and tick_count is 0.
- R3: While running, qtick_stb is a one-cycle pulse every 12 clocks, and tick_count rises by one at each pulse.
- R4: After tick frame_len-1 the counter returns to 0. frame_start pulses in that same cycle, together with qtick_stb. This includes the default frame length of 5000 ticks.
- R5: A valid entry with time T is applied in the cycle where qtick_stb is 1 and tick_count is T. Each act_out bit whose mask bit is 1 takes the value bit, and the other bits keep their state.
- R6: act_out bits 5 to 8 are always 0, whatever the masks request.
- R7: When several entries match the same tick, they are applied in ascending index order. Masks merge, and on an overlapping bit the higher index decides.
- R8: On a matching tick, ser_req pulses for one cycle and ser_word carries the word of the lowest-index matching entry whose send flag is 1. Entries with send 0 request nothing. ser_word keeps its value between requests.
- R9: A write with wr_en high replaces the whole entry at wr_addr, and it takes effect from the next tick on, also while running. Entries written with wr_valid 0 have no effect.
- R10: The table persists, so the same events fire again in every frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 13 MHz system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Global run enable; a rising value starts the count at tick 0 |
| frame_len | input | 13 | Frame length in ticks (nominally 5000) |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | 4 | Entry index to write |
| wr_valid | input | 1 | Valid flag of the written entry |
| wr_tick | input | 13 | Tick time of the written entry |
| wr_val | input | 10 | Control-line values of the written entry |
| wr_mask | input | 10 | Control-line write mask of the written entry |
| wr_send | input | 1 | Serial request flag of the written entry |
| wr_word | input | 7 | Serial payload of the written entry |
| qtick_stb | output | 1 | One-cycle pulse at the start of each tick |
| tick_count | output | 13 | Current tick within the frame |
| frame_start | output | 1 | One-cycle pulse at the start of tick 0 |
| act_out | output | 10 | Control lines; only bits 0-4 and 9 are driven |
| ser_req | output | 1 | One-cycle serial transfer request |
| ser_word | output | 7 | Payload for the serial engine |

## Verification
The properties assume that frame_len is at least 2 and does not change while run_en is high. Under that assumption the counter only climbs by one per strobe or falls to zero. The properties also assume a divide ratio of at least two, so that strobes can never fall in adjacent cycles. The directed stimulus changes frame_len only while the run is stopped, and it uses only the values 20 and 5000. Table writes happen at any point in the tick, because a write that lands on a strobe cycle is defined to act from the next tick on.

// File: rtl/qes_pkg.sv
package qes_pkg;
  localparam int QES_TICK_W = 13;
  localparam int QES_LINE_W = 10;
  localparam int QES_WORD_W = 7;

  typedef struct packed {
    logic                  valid;
    logic [QES_TICK_W-1:0] at;
    logic [QES_LINE_W-1:0] val;
    logic [QES_LINE_W-1:0] mask;
    logic                  send;
    logic [QES_WORD_W-1:0] word;
  } qes_entry_t;
endpackage

// File: rtl/qes_rst_sync.sv
module qes_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/qes_tick_gen.sv
module qes_tick_gen #(
  parameter int DIV = 12,
  parameter int TW  = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_en,
  input  logic [TW-1:0] frame_len,
  output logic          load,
  output logic [TW-1:0] tick_nxt,
  output logic [TW-1:0] tick_q,
  output logic          stb_q,
  output logic          fstart_q
);
  localparam int            DW       = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(DIV - 1);

  logic [DW-1:0] div_q, div_d;
  logic [TW-1:0] tick_d;
  logic          run_q, run_d;
  logic          stb_d, fstart_d;
  logic          start, adv, wrap;
  logic [TW-1:0] last_tick;

  always_comb begin
    start     = run_en & ~run_q;
    adv       = run_en & run_q & (div_q == DIV_LAST);
    load      = start | adv;
    last_tick = frame_len - 1'b1;
    wrap      = (tick_q >= last_tick);

    if (start || wrap) tick_nxt = '0;
    else               tick_nxt = tick_q + 1'b1;

    if (!run_en)                         div_d = '0;
    else if (start || div_q == DIV_LAST) div_d = '0;
    else                                 div_d = div_q + 1'b1;

    if (!run_en)   tick_d = '0;
    else if (load) tick_d = tick_nxt;
    else           tick_d = tick_q;

    run_d    = run_en;
    stb_d    = load;
    fstart_d = load & (tick_nxt == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q    <= '0;
      tick_q   <= '0;
      run_q    <= 1'b0;
      stb_q    <= 1'b0;
      fstart_q <= 1'b0;
    end else begin
      div_q    <= div_d;
      tick_q   <= tick_d;
      run_q    <= run_d;
      stb_q    <= stb_d;
      fstart_q <= fstart_d;
    end
  end
endmodule

// File: rtl/qes_event_table.sv
module qes_event_table
  import qes_pkg::*;
#(
  parameter int N_ENT = 16
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr_en,
  input  logic [$clog2(N_ENT)-1:0]             wr_addr,
  input  qes_entry_t                           wr_ent,
  input  logic [QES_TICK_W-1:0]                tick_nxt,
  output logic [N_ENT-1:0]                     match,
  output logic [N_ENT-1:0][QES_LINE_W-1:0]     val_o,
  output logic [N_ENT-1:0][QES_LINE_W-1:0]     mask_o,
  output logic [N_ENT-1:0]                     send_o,
  output logic [N_ENT-1:0][QES_WORD_W-1:0]     word_o
);
  localparam int AW = $clog2(N_ENT);

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    qes_entry_t ent_q, ent_d;
    logic       sel;

    always_comb begin
      sel   = wr_en && (wr_addr == AW'(g));
      ent_d = sel ? wr_ent : ent_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent_q <= '0;
      else        ent_q <= ent_d;
    end

    assign match[g]  = ent_q.valid && (ent_q.at == tick_nxt);
    assign val_o[g]  = ent_q.val;
    assign mask_o[g] = ent_q.mask;
    assign send_o[g] = ent_q.send;
    assign word_o[g] = ent_q.word;
  end
endmodule

// File: rtl/qes_dispatch.sv
module qes_dispatch
  import qes_pkg::*;
#(
  parameter int                    N_ENT     = 16,
  parameter logic [QES_LINE_W-1:0] LINE_MASK = 10'b10_0001_1111
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             load,
  input  logic [N_ENT-1:0]                 match,
  input  logic [N_ENT-1:0][QES_LINE_W-1:0] val_i,
  input  logic [N_ENT-1:0][QES_LINE_W-1:0] mask_i,
  input  logic [N_ENT-1:0]                 send_i,
  input  logic [N_ENT-1:0][QES_WORD_W-1:0] word_i,
  output logic [QES_LINE_W-1:0]            act_q,
  output logic                             req_q,
  output logic [QES_WORD_W-1:0]            word_q
);
  logic [QES_LINE_W-1:0] merged, act_d;
  logic [QES_WORD_W-1:0] pick, word_d;
  logic                  hit, req_d;

  always_comb begin
    // ascending index: a later entry overrides earlier ones on shared bits
    merged = act_q;
    for (int i = 0; i < N_ENT; i++) begin
      if (match[i]) merged = (merged & ~mask_i[i]) | (val_i[i] & mask_i[i]);
    end

    // descending scan leaves the lowest requesting index in pick
    hit  = 1'b0;
    pick = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (match[i] && send_i[i]) begin
        hit  = 1'b1;
        pick = word_i[i];
      end
    end

    act_d  = load ? (merged & LINE_MASK) : act_q;
    req_d  = load & hit;
    word_d = (load && hit) ? pick : word_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= '0;
      req_q  <= 1'b0;
      word_q <= '0;
    end else begin
      act_q  <= act_d;
      req_q  <= req_d;
      word_q <= word_d;
    end
  end
endmodule

// File: rtl/qbit_event_sched.sv
module qbit_event_sched
  import qes_pkg::*;
#(
  parameter int                    DIV       = 12,
  parameter int                    N_ENT     = 16,
  parameter logic [QES_LINE_W-1:0] LINE_MASK = 10'b10_0001_1111
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run_en,
  input  logic [QES_TICK_W-1:0]    frame_len,
  input  logic                     wr_en,
  input  logic [$clog2(N_ENT)-1:0] wr_addr,
  input  logic                     wr_valid,
  input  logic [QES_TICK_W-1:0]    wr_tick,
  input  logic [QES_LINE_W-1:0]    wr_val,
  input  logic [QES_LINE_W-1:0]    wr_mask,
  input  logic                     wr_send,
  input  logic [QES_WORD_W-1:0]    wr_word,
  output logic                     qtick_stb,
  output logic [QES_TICK_W-1:0]    tick_count,
  output logic                     frame_start,
  output logic [QES_LINE_W-1:0]    act_out,
  output logic                     ser_req,
  output logic [QES_WORD_W-1:0]    ser_word
);
  logic                            rst_sync_n;
  logic                            load;
  logic [QES_TICK_W-1:0]           tick_nxt;
  logic [N_ENT-1:0]                match;
  logic [N_ENT-1:0][QES_LINE_W-1:0] ent_val, ent_mask;
  logic [N_ENT-1:0]                ent_send;
  logic [N_ENT-1:0][QES_WORD_W-1:0] ent_word;
  qes_entry_t                      wr_ent;

  always_comb begin
    wr_ent.valid = wr_valid;
    wr_ent.at    = wr_tick;
    wr_ent.val   = wr_val;
    wr_ent.mask  = wr_mask;
    wr_ent.send  = wr_send;
    wr_ent.word  = wr_word;
  end

  qes_rst_sync #(.STAGES(2)) rst_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  qes_tick_gen #(.DIV(DIV), .TW(QES_TICK_W)) tick_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .run_en    (run_en),
    .frame_len (frame_len),
    .load      (load),
    .tick_nxt  (tick_nxt),
    .tick_q    (tick_count),
    .stb_q     (qtick_stb),
    .fstart_q  (frame_start)
  );

  qes_event_table #(.N_ENT(N_ENT)) table_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_ent   (wr_ent),
    .tick_nxt (tick_nxt),
    .match    (match),
    .val_o    (ent_val),
    .mask_o   (ent_mask),
    .send_o   (ent_send),
    .word_o   (ent_word)
  );

  qes_dispatch #(.N_ENT(N_ENT), .LINE_MASK(LINE_MASK)) disp_i (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .load   (load),
    .match  (match),
    .val_i  (ent_val),
    .mask_i (ent_mask),
    .send_i (ent_send),
    .word_i (ent_word),
    .act_q  (act_out),
    .req_q  (ser_req),
    .word_q (ser_word)
  );
endmodule

// File: rtl/qes_chk.sv
module qes_chk
  import qes_pkg::*;
#(
  parameter logic [QES_LINE_W-1:0] LINE_MASK = 10'b10_0001_1111
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  run_en,
  input logic                  qtick_stb,
  input logic [QES_TICK_W-1:0] tick_count,
  input logic                  frame_start,
  input logic [QES_LINE_W-1:0] act_out,
  input logic                  ser_req
);
  // R6
  line_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_out & ~LINE_MASK) == '0);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (tick_count == '0) && !qtick_stb);

  // R3
  stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    qtick_stb |=> !qtick_stb);

  // R3
  tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (qtick_stb && tick_count != '0) |->
      tick_count == QES_TICK_W'($past(tick_count) + 1'b1));

  // R4
  frame_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (tick_count == '0) && qtick_stb);

  // R5
  act_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !qtick_stb |-> $stable(act_out));

  // R8
  req_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_req |-> qtick_stb);
endmodule

bind qbit_event_sched qes_chk #(.LINE_MASK(LINE_MASK)) chk_i (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .run_en      (run_en),
  .qtick_stb   (qtick_stb),
  .tick_count  (tick_count),
  .frame_start (frame_start),
  .act_out     (act_out),
  .ser_req     (ser_req)
);

// File: tb/qbit_event_sched_tb_top.sv
module qbit_event_sched_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_en = 1'b0;
  logic [12:0] frame_len = 13'd20;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic        wr_valid = 1'b0;
  logic [12:0] wr_tick = '0;
  logic [9:0]  wr_val = '0;
  logic [9:0]  wr_mask = '0;
  logic        wr_send = 1'b0;
  logic [6:0]  wr_word = '0;
  logic        qtick_stb;
  logic [12:0] tick_count;
  logic        frame_start;
  logic [9:0]  act_out;
  logic        ser_req;
  logic [6:0]  ser_word;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  qbit_event_sched dut_i (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .frame_len(frame_len),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_valid(wr_valid), .wr_tick(wr_tick),
    .wr_val(wr_val), .wr_mask(wr_mask), .wr_send(wr_send), .wr_word(wr_word),
    .qtick_stb(qtick_stb), .tick_count(tick_count), .frame_start(frame_start),
    .act_out(act_out), .ser_req(ser_req), .ser_word(ser_word)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  task automatic write_entry(input int idx, input bit v, input int t,
                             input int val, input int mask, input bit snd, input int word);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(idx); wr_valid = v; wr_tick = 13'(t);
    wr_val = 10'(val); wr_mask = 10'(mask); wr_send = snd; wr_word = 7'(word);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // waits (sampling at negedge) for the strobe cycle of tick t
  task automatic wait_tick(input int t, input int lim, input string req);
    int  n = 0;
    bit  done = 1'b0;
    while (!done) begin
      @(negedge clk);
      if (qtick_stb && tick_count == 13'(t)) done = 1'b1;
      else begin
        n++;
        if (n > lim) begin
          chk({req, " timeout waiting for tick"}, 0, 1);
          done = 1'b1;
        end
      end
    end
  endtask

  task automatic t_reset();
    int reqs = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 act_out", act_out, 0);
    chk("R1 ser_req", ser_req, 0);
    chk("R1 tick_count", tick_count, 0);
    chk("R1 qtick_stb", qtick_stb, 0);
    chk("R1 frame_start", frame_start, 0);
    run_en = 1'b1;
    repeat (40) begin
      @(negedge clk);
      if (ser_req || act_out != 0) reqs++;
    end
    chk("R1 empty table fires nothing", reqs, 0);
    run_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_idle();
    int stbs = 0;
    write_entry(0, 1, 0, 'h01F, 'h003, 0, 0);
    repeat (40) begin
      @(negedge clk);
      if (qtick_stb) stbs++;
    end
    chk("R2 no strobe while idle", stbs, 0);
    chk("R2 tick held at 0", tick_count, 0);
    chk("R2 no event while idle", act_out, 0);
  endtask

  task automatic t_schedule();
    int n;
    write_entry(1, 1, 5, 'h3FF, 'h3E4, 0, 'h11);
    write_entry(2, 1, 5, 'h000, 'h200, 0, 'h22);
    write_entry(3, 1, 5, 'h000, 'h000, 1, 'h55);
    write_entry(4, 1, 5, 'h000, 'h000, 1, 'h2A);
    write_entry(5, 0, 8, 'h3FF, 'h3FF, 1, 'h33);
    write_entry(6, 1, 12, 'h000, 'h001, 1, 'h7F);
    frame_len = 13'd20;
    @(negedge clk);
    run_en = 1'b1;
    @(negedge clk);
    chk("R2 start strobe", qtick_stb, 1);
    chk("R2 start frame_start", frame_start, 1);
    chk("R2 start tick 0", tick_count, 0);
    chk("R5 entry at tick 0", act_out, 'h003);
    n = 0;
    do begin @(negedge clk); n++; end while (!qtick_stb && n < 40);
    chk("R3 strobe period", n, 12);
    chk("R3 tick increments", tick_count, 1);
    wait_tick(4, 100, "R5");
    chk("R5 nothing before tick 5", act_out, 'h003);
    wait_tick(5, 20, "R7");
    chk("R7 merged masks, higher index wins", act_out, 'h007);
    chk("R8 request on tick", ser_req, 1);
    chk("R8 lowest-index sender word", ser_word, 'h55);
    @(negedge clk);
    chk("R8 request is one cycle", ser_req, 0);
    chk("R8 word held", ser_word, 'h55);
    wait_tick(8, 60, "R9");
    chk("R9 invalid entry ignored", act_out, 'h007);
    chk("R9 invalid entry no request", ser_req, 0);
    wait_tick(12, 60, "R5");
    chk("R5 clear line 0 at tick 12", act_out, 'h006);
    chk("R8 second request word", ser_word, 'h7F);
    wait_tick(19, 120, "R4");
    chk("R4 no frame_start at last tick", frame_start, 0);
    wait_tick(0, 20, "R4");
    chk("R4 wrap with frame_start", frame_start, 1);
    chk("R10 tick 0 event repeats", act_out, 'h007);
    chk("R6 lines 5-8 low", int'(act_out[8:5]), 0);
    // rewrite entry 5 while running
    write_entry(5, 1, 3, 'h000, 'h3FF, 0, 0);
    wait_tick(3, 60, "R9");
    chk("R9 live write takes effect", act_out, 'h000);
    wait_tick(5, 40, "R10");
    chk("R10 tick 5 repeats", act_out, 'h004);
    chk("R10 request repeats", ser_word, 'h55);
    @(negedge clk);
    run_en = 1'b0;
    @(negedge clk);
    chk("R2 stop returns tick to 0", tick_count, 0);
    chk("R2 stop holds act_out", act_out, 'h004);
  endtask

  task automatic t_default_frame();
    frame_len = 13'd5000;
    @(negedge clk);
    run_en = 1'b1;
    wait_tick(4999, 70000, "R4");
    chk("R4 last tick of default frame", tick_count, 4999);
    chk("R4 no early frame_start", frame_start, 0);
    wait_tick(0, 20, "R4");
    chk("R4 default frame wrap", frame_start, 1);
    run_en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    t_reset();
    t_idle();
    t_schedule();
    t_default_frame();
    summary();
  end
endmodule